// File: doc/BRIEF.md
# Multichannel ADC Word Serializer

This block takes one parallel conversion word per channel each frame and sends each word out as a bit-serial stream, with one output per channel. It runs on a fast serial clock whose rate is one bit slot per cycle, so a frame lasts `WORD_W` cycles. Alongside the data it produces two forwarded clocks from the same slot counter as the data:

- a frame clock that marks where each word begins;
- a bit clock at half the slot rate, so the data changes on both of its edges.

The parallel words are copied into a shadow register at every frame boundary. A word that changes while a frame is being shifted out therefore cannot corrupt that frame. The configuration is sampled at the same boundary. It covers the pattern choice, the bit order, the custom nibbles and the per-channel enables.

A frame boundary happens in two ways. The slot counter can wrap on its own, or the frame-start input can be pulsed to force a restart. Instead of live data, the block can send one of three calibration patterns:

- an alternating pattern for aligning the bit clock to the data;
- a half-zeros/half-ones pattern for finding frame boundaries;
- a pattern made from three configuration nibbles.

The bit order (least or most significant bit first) applies to the patterns as well as to live data.

Top module: `adc_word_serializer`

## Requirements
- R1: While reset is low, and in the cycle after it is released, every `ser_o` bit, `frame_clk_o` and `bit_clk_o` are 0.
- R2: `word_i`, `pat_sel_i`, `msb_first_i`, the custom nibbles and `chan_on_i` are captured only at a frame boundary. A frame boundary is a clock edge where `frame_start_i` is 1 or the last slot is showing. Changing these inputs during a frame does not alter the frame in flight. The new values appear from slot 0 of the next frame.
- R3: With `msb_first_i` = 0, slot k (k = 0 first) of each channel carries bit k of that channel's captured word. Channel c occupies `word_i[c*12 +: 12]`.
- R4: With `msb_first_i` = 1, slot k carries bit 11-k of the word.
- R5: The `pat_sel_i` codes select the source for all channels:

  | `pat_sel_i` | Source | Stream when `msb_first_i` = 0 |
  |---|---|---|
  | 00 | live data | the captured word, per R3 |
  | 01 | alignment pattern | 1,0,1,0,... starting at slot 0 |
  | 10 | boundary pattern | 0 for slots 0-5, 1 for slots 6-11 |
  | 11 | custom word {`cust_hi_i`, `cust_mid_i`, `cust_lo_i`} | `cust_hi_i` is bits 11:8, sent as in R3 |
- R6: With `msb_first_i` = 1, each pattern stream is sent in reverse order. The alignment pattern becomes 0,1,0,1,..., the boundary pattern becomes six 1s then six 0s, and the custom word is sent bit 11 first.
- R7: `frame_clk_o` is 1 in slots 0-5 and 0 in slots 6-11. Its rising edge marks slot 0, the first bit of a word. Without restarts it repeats every 12 cycles.
- R8: `bit_clk_o` is 1 in even slots and 0 in odd slots. It toggles every cycle while the counter runs freely, and it is 1 whenever `frame_clk_o` rises.
- R9: A channel whose `chan_on_i` bit (1 = powered up) was 0 at the last frame boundary drives 0 in every slot of that frame, whatever the pattern.
- R10: A cycle with `frame_start_i` = 1 makes the next cycle show slot 0 of a new frame, even in mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial slot clock, one bit slot per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | Forces a frame boundary at this edge |
| word_i | input | NUM_CH*WORD_W | Parallel words, channel c at [c*WORD_W +: WORD_W] |
| pat_sel_i | input | 2 | Source select: 00 live, 01 alignment, 10 boundary, 11 custom |
| msb_first_i | input | 1 | 1 = most significant bit first |
| cust_hi_i | input | NIB_W | Custom pattern, top nibble |
| cust_mid_i | input | NIB_W | Custom pattern, middle nibble |
| cust_lo_i | input | NIB_W | Custom pattern, low nibble |
| chan_on_i | input | NUM_CH | Per-channel power-up enable |
| ser_o | output | NUM_CH | Serial data, one bit per channel |
| frame_clk_o | output | 1 | Forwarded frame clock |
| bit_clk_o | output | 1 | Forwarded bit clock, half the slot rate |

## Verification
Two events can fall in the same cycle: a forced restart through `frame_start_i`, and the capture of new words and configuration. They can also coincide with an input change in mid-frame. The bench changes `word_i`, `pat_sel_i` and `msb_first_i` part-way through a frame and checks that the remaining slots still carry the old word. It then checks that the next self-wrapped frame carries the new values. In a second case it pulses `frame_start_i` at slot 4 together with a new word. It judges the restart by seeing slot 0 of the new word on the next cycle, with `frame_clk_o` high and `bit_clk_o` high, and the full new frame following.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  typedef enum logic [1:0] {
    SRC_LIVE   = 2'b00,
    SRC_ALIGN  = 2'b01,
    SRC_BOUND  = 2'b10,
    SRC_CUSTOM = 2'b11
  } src_sel_e;

  // Bit position sent in a given slot for the chosen order.
  function automatic int unsigned slot_to_bit(int unsigned slot,
                                              logic msb_first,
                                              int unsigned word_w);
    return msb_first ? (word_w - 1 - slot) : slot;
  endfunction

  // Alignment word: ones on even bit positions.
  function automatic logic align_bit(int unsigned pos);
    return (pos % 2) == 0;
  endfunction

  // Boundary word: upper half ones, lower half zeros.
  function automatic logic bound_bit(int unsigned pos, int unsigned word_w);
    return pos >= (word_w / 2);
  endfunction

endpackage

// File: rtl/ser_slot_ctr.sv
module ser_slot_ctr #(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned SLOT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_edge_o
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(WORD_W - 1);

  logic [SLOT_W-1:0] slot_q;

  // Boundary: forced restart or natural wrap after the last slot.
  assign frame_edge_o = frame_start_i || (slot_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      slot_q <= LAST;
    end else if (frame_edge_o) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/ser_frame_regs.sv
module ser_frame_regs
  import adc_ser_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned WORD_W = 12,
  parameter int unsigned NIB_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_edge_i,
  input  logic [NUM_CH*WORD_W-1:0] word_i,
  input  logic [1:0]               pat_sel_i,
  input  logic                     msb_first_i,
  input  logic [NIB_W-1:0]         cust_hi_i,
  input  logic [NIB_W-1:0]         cust_mid_i,
  input  logic [NIB_W-1:0]         cust_lo_i,
  input  logic [NUM_CH-1:0]        chan_on_i,
  output logic [NUM_CH*WORD_W-1:0] word_q_o,
  output src_sel_e                 src_q_o,
  output logic                     msb_q_o,
  output logic [WORD_W-1:0]        cust_q_o,
  output logic [NUM_CH-1:0]        en_q_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      word_q_o <= '0;
      src_q_o  <= SRC_LIVE;
      msb_q_o  <= 1'b0;
      cust_q_o <= '0;
      en_q_o   <= '0;
    end else if (frame_edge_i) begin
      word_q_o <= word_i;
      src_q_o  <= src_sel_e'(pat_sel_i);
      msb_q_o  <= msb_first_i;
      cust_q_o <= {cust_hi_i, cust_mid_i, cust_lo_i};
      en_q_o   <= chan_on_i;
    end
  end

endmodule

// File: rtl/ser_lane.sv
module ser_lane
  import adc_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned SLOT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] cust_i,
  input  src_sel_e          src_i,
  input  logic              msb_i,
  input  logic              en_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              bit_o
);

  int unsigned pos;

  always_comb begin
    pos = slot_to_bit(int'(slot_i), msb_i, WORD_W);
    unique case (src_i)
      SRC_LIVE:   bit_o = word_i[pos];
      SRC_ALIGN:  bit_o = align_bit(pos);
      SRC_BOUND:  bit_o = bound_bit(pos, WORD_W);
      SRC_CUSTOM: bit_o = cust_i[pos];
      default:    bit_o = 1'b0;
    endcase
    if (!en_i) begin
      bit_o = 1'b0;
    end
  end

endmodule

// File: rtl/adc_word_serializer.sv
module adc_word_serializer
  import adc_ser_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned WORD_W = 3 * NIB_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_start_i,
  input  logic [NUM_CH*WORD_W-1:0] word_i,
  input  logic [1:0]               pat_sel_i,
  input  logic                     msb_first_i,
  input  logic [NIB_W-1:0]         cust_hi_i,
  input  logic [NIB_W-1:0]         cust_mid_i,
  input  logic [NIB_W-1:0]         cust_lo_i,
  input  logic [NUM_CH-1:0]        chan_on_i,
  output logic [NUM_CH-1:0]        ser_o,
  output logic                     frame_clk_o,
  output logic                     bit_clk_o
);

  localparam int unsigned SLOT_W = $clog2(WORD_W);
  localparam logic [SLOT_W-1:0] HALF = SLOT_W'(WORD_W / 2);

  // Named internal events, observed by the bound checker.
  logic [SLOT_W-1:0]        slot_q;
  logic                     frame_edge;
  logic [NUM_CH*WORD_W-1:0] word_q;
  src_sel_e                 src_q;
  logic                     msb_q;
  logic [WORD_W-1:0]        cust_q;
  logic [NUM_CH-1:0]        en_q;

  ser_slot_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .slot_o        (slot_q),
    .frame_edge_o  (frame_edge)
  );

  ser_frame_regs #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .NIB_W(NIB_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_edge_i (frame_edge),
    .word_i       (word_i),
    .pat_sel_i    (pat_sel_i),
    .msb_first_i  (msb_first_i),
    .cust_hi_i    (cust_hi_i),
    .cust_mid_i   (cust_mid_i),
    .cust_lo_i    (cust_lo_i),
    .chan_on_i    (chan_on_i),
    .word_q_o     (word_q),
    .src_q_o      (src_q),
    .msb_q_o      (msb_q),
    .cust_q_o     (cust_q),
    .en_q_o       (en_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    ser_lane #(.WORD_W(WORD_W)) u_lane (
      .word_i (word_q[c*WORD_W +: WORD_W]),
      .cust_i (cust_q),
      .src_i  (src_q),
      .msb_i  (msb_q),
      .en_i   (en_q[c]),
      .slot_i (slot_q),
      .bit_o  (ser_o[c])
    );
  end

  // Forwarded clocks decode the same slot register as the data.
  assign frame_clk_o = (slot_q < HALF);
  assign bit_clk_o   = ~slot_q[0];

endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned WORD_W = 12,
  localparam int unsigned SLOT_W = $clog2(WORD_W)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     frame_start_i,
  input logic [NUM_CH-1:0]        ser_o,
  input logic                     frame_clk_o,
  input logic                     bit_clk_o,
  input logic [SLOT_W-1:0]        slot,
  input logic                     frame_edge,
  input logic [NUM_CH-1:0]        en_q,
  input logic [NUM_CH*WORD_W-1:0] word_q
);

  // R9: a lane switched off at the boundary stays silent
  p_off_lane_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_o & ~en_q) == '0);

  // R8: bit clock toggles every cycle unless a restart intervened
  p_bitclk_toggle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(frame_start_i)) |-> (bit_clk_o != $past(bit_clk_o)));

  // R8: frame clock rises together with a high bit clock at slot 0
  p_rise_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_clk_o) |-> (bit_clk_o && slot == '0));

  // R7: every frame clock rise follows a boundary
  p_rise_after_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_clk_o) |-> $past(frame_edge));

  // R2: shadow words move only at a boundary
  p_shadow_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(frame_edge)) |-> $stable(word_q));

  // R10: a restart request shows slot 0 next cycle
  p_restart_slot0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(frame_start_i)) |-> (slot == '0));

endmodule

bind adc_word_serializer ser_checker #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .ser_o         (ser_o),
  .frame_clk_o   (frame_clk_o),
  .bit_clk_o     (bit_clk_o),
  .slot          (slot_q),
  .frame_edge    (frame_edge),
  .en_q          (en_q),
  .word_q        (word_q)
);

// File: tb/sim_adc_word_serializer.sv
`timescale 1ns/1ps
module sim_adc_word_serializer;

  localparam int NCH = 8;
  localparam int NIB = 4;
  localparam int W   = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, fstart, msb;
  logic [NCH*W-1:0] words;
  logic [1:0]       pat;
  logic [NIB-1:0]   c_hi, c_mid, c_lo;
  logic [NCH-1:0]   chan_on;
  logic [NCH-1:0]   ser;
  logic             fclk, bclk;

  adc_word_serializer #(.NUM_CH(NCH), .NIB_W(NIB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fstart), .word_i(words),
    .pat_sel_i(pat), .msb_first_i(msb), .cust_hi_i(c_hi), .cust_mid_i(c_mid),
    .cust_lo_i(c_lo), .chan_on_i(chan_on), .ser_o(ser), .frame_clk_o(fclk),
    .bit_clk_o(bclk)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected serial bit per lane, from the requirement tables.
  function automatic logic [NCH-1:0] model(logic [1:0] p, logic m, logic [NCH*W-1:0] wd,
                                           logic [W-1:0] cu, logic [NCH-1:0] en, int t);
    logic [NCH-1:0] r;
    int i;
    i = m ? (W - 1 - t) : t;  // R6: reversed stream in msb mode
    for (int c = 0; c < NCH; c++) begin
      case (p)
        2'b00:   r[c] = wd[c*W + i];
        2'b01:   r[c] = (i % 2 == 0);
        2'b10:   r[c] = (i >= 6);
        default: r[c] = cu[i];
      endcase
      if (!en[c]) r[c] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [NCH*W-1:0] spread(logic [W-1:0] seed);
    logic [NCH*W-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*W +: W] = seed ^ W'(c * 419);
    return r;
  endfunction

  // Entry: slot k0 is visible now. Exit: slot k1 visible.
  task automatic check_range(string tag, int k0, int k1, logic [1:0] p, logic m,
                             logic [NCH*W-1:0] wd, logic [W-1:0] cu, logic [NCH-1:0] en);
    for (int k = k0; k <= k1; k++) begin
      chk(tag, 32'(ser), 32'(model(p, m, wd, cu, en, k)));
      chk("R7 frame clock", 32'(fclk), 32'(k < 6));
      chk("R8 bit clock", 32'(bclk), 32'(k % 2 == 0));
      if (k < k1) @(negedge clk);
    end
  endtask

  task automatic start_frame();
    fstart = 1'b1;
    @(negedge clk);
    fstart = 1'b0;
  endtask

  // Vector: pat[26:25], msb[24], seed[23:12], custom[11:0]
  localparam logic [26:0] VEC [8] = '{
    {2'b00, 1'b0, 12'hA5C, 12'h000},
    {2'b00, 1'b1, 12'h3E1, 12'h000},
    {2'b01, 1'b0, 12'h777, 12'h000},
    {2'b01, 1'b1, 12'h123, 12'h000},
    {2'b10, 1'b0, 12'hFFF, 12'h000},
    {2'b10, 1'b1, 12'h000, 12'h000},
    {2'b11, 1'b0, 12'h456, 12'h9B4},
    {2'b11, 1'b1, 12'h456, 12'hC31}
  };

  initial begin
    logic [NCH*W-1:0] wa, wb;
    string tag;
    rst_n = 1'b0; fstart = 1'b0; msb = 1'b0; pat = 2'b00;
    words = spread(12'hFFF); c_hi = '0; c_mid = '0; c_lo = '0; chan_on = '1;
    repeat (3) @(negedge clk);
    chk("R1 reset lanes", 32'(ser), 32'h0);
    chk("R1 reset clocks", 32'({fclk, bclk}), 32'h0);
    rst_n = 1'b1;
    chk("R1 release lanes", 32'(ser), 32'h0);
    chk("R1 release clocks", 32'({fclk, bclk}), 32'h0);
    @(negedge clk);

    // Table walk: R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      pat = VEC[v][26:25]; msb = VEC[v][24];
      words = spread(VEC[v][23:12]);
      {c_hi, c_mid, c_lo} = VEC[v][11:0];
      tag = (pat == 2'b00) ? (msb ? "R4 live msb" : "R3 live lsb")
                           : (msb ? "R6 pattern msb" : "R5 pattern lsb");
      start_frame();
      check_range(tag, 0, W - 1, pat, msb, words, VEC[v][11:0], chan_on);
      @(negedge clk);
    end

    // R2 / R11-style mid-frame changes: old frame intact, next wrap picks up new
    wa = spread(12'h5A3); wb = spread(12'hC0F);
    pat = 2'b00; msb = 1'b0; words = wa;
    start_frame();
    check_range("R2 before change", 0, 2, 2'b00, 1'b0, wa, '0, chan_on);
    words = wb; pat = 2'b01; msb = 1'b1;
    @(negedge clk);
    check_range("R2 frame in flight", 3, W - 1, 2'b00, 1'b0, wa, '0, chan_on);
    @(negedge clk);
    check_range("R2 next frame", 0, W - 1, 2'b01, 1'b1, wb, '0, chan_on);

    // R9: lanes 2 and 5 off, live ones and boundary pattern
    chan_on = 8'b1101_1011; pat = 2'b00; msb = 1'b0; words = '1;
    start_frame();
    check_range("R9 off lanes live", 0, W - 1, 2'b00, 1'b0, words, '0, chan_on);
    pat = 2'b10;
    @(negedge clk);
    check_range("R9 off lanes pattern", 0, W - 1, 2'b10, 1'b0, words, '0, chan_on);
    chan_on = '1;
    @(negedge clk);

    // R10: restart at slot 4 with a new word
    pat = 2'b00; words = wa;
    start_frame();
    check_range("R10 before restart", 0, 4, 2'b00, 1'b0, wa, '0, chan_on);
    words = wb;
    start_frame();
    check_range("R10 restarted frame", 0, W - 1, 2'b00, 1'b0, wb, '0, chan_on);
    @(negedge clk);
    check_range("R7 free-run wrap", 0, W - 1, 2'b00, 1'b0, wb, '0, chan_on);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule